// File: doc/BRIEF.md
# Dual-Half Hamming ECC Generator for a NAND Data Path

This block sits beside the 16-bit data register of a NAND flash host interface and builds an error-correcting code while a 512-byte sector moves through that register. The sector is split at byte 256 into two halves, and each half gets its own Hamming code. That code has 16 line-parity bits, which locate the byte, and 6 column-parity bits, which locate the bit within the byte. Because each half carries its own code, one flipped bit can be corrected in each half, so a sector can have up to two corrected bits. Correction and syndrome decoding are done by other logic.

Software drives the block with 8-bit mode codes. One code clears the accumulators. The usual sequence is to clear, make one dummy read of the data register, start accumulation, stream the sector, switch to result readout, and read three 16-bit words. The six code bytes are packed across those three words in a fixed interleaved order. Writing the data-mode code then returns the register to plain transfers.

Top module: `nand_ecc_dual`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), both codes are cleared, the block is in data mode, the readout pointer is 0, and `res_word` reads 0x0000.
- R2: Mode code 0xF4 clears both codes, the byte index and the readout pointer. A data word presented while the block is in this cleared mode (the dummy read) leaves the codes unchanged.
- R3: After mode code 0xB4, each `dat_valid` word adds two bytes to the code: the low byte `dat_word[7:0]` at byte index i and the high byte `dat_word[15:8]` at index i+1. The index then advances by 2.
- R4: Within a half, let a be the 8-bit byte address. For each address bit k, line-parity bit 2k+1 is the XOR of the parities of all bytes whose a[k] is 1, and bit 2k is the XOR of the parities of all bytes whose a[k] is 0.
- R5: Column parity bits are defined over bit positions of every byte in the half:
  - CP0 is the XOR of bits {0,2,4,6}.
  - CP1 is the XOR of bits {1,3,5,7}.
  - CP2 is the XOR of bits {0,1,4,5}.
  - CP3 is the XOR of bits {2,3,6,7}.
  - CP4 is the XOR of bits 0..3.
  - CP5 is the XOR of bits 4..7.
  
  The column byte is {CP5..CP0, 2'b11}. No parity bit is inverted.
- R6: Bytes 0 to 255 feed the first code and bytes 256 to 511 feed the second code. The switch between them is automatic.
- R7: Once 512 bytes have been accumulated, further data words do not change either code.
- R8: Mode code 0xD4 sets the readout pointer to 0. `res_word` always shows the word the pointer selects, where L and H are the line-parity bits of the first and second half and CA and CB are their column bytes:

  | Pointer | `res_word` |
  |---|---|
  | 0 | {L[15:8], L[7:0]} |
  | 1 | {H[7:0], CA} |
  | 2 | {CB, H[15:8]} |
- R9: In result mode, each `res_rd` pulse advances the pointer. A read at word 2 wraps the pointer back to word 0.
- R10: Mode code 0x94 selects data mode. In data mode, `dat_valid` and `res_rd` leave the codes and the pointer unchanged.
- R11: A mode write with any code other than 0xF4, 0xB4, 0xD4 or 0x94 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Mode-code write strobe |
| mode_code | input | 8 | Mode code written with `mode_we` |
| dat_valid | input | 1 | A 16-bit word crosses the data register this cycle |
| dat_word | input | 16 | That word, low byte first in sector order |
| res_rd | input | 1 | Read strobe for one result word |
| res_word | output | 16 | Result word selected by the readout pointer |

## Verification
Some properties are checked on every cycle:
- The byte index never exceeds 512 and advances by exactly 2 per accepted word.
- The readout pointer stays below 3 and wraps after word 2.
- A clear mode write zeroes the index and the pointer.
- `res_word` holds steady in data mode.
- The two fixed low bits of each column byte read as ones.

Other behaviour only the bench scenarios can show:
- The parity values themselves.
- The split between the two halves, including a single set bit placed in the second half.
- That the dummy read, bytes past the end of the sector and unrecognised codes leave the code untouched.

// File: rtl/nand_ecc_pkg.sv
// Shared constants and types for the dual-half NAND ECC generator.
// Assumes a 256-byte half, so each line-parity field is 16 bits wide.
package nand_ecc_pkg;
    localparam int HALF_BYTES   = 256;
    localparam int ADDR_W       = $clog2(HALF_BYTES);
    localparam int LP_W         = 2 * ADDR_W;
    localparam int SECTOR_BYTES = 2 * HALF_BYTES;
    localparam int CNT_W        = $clog2(SECTOR_BYTES) + 1;
    localparam int WORD_W       = 16;
    localparam int NUM_RES      = 3;
    localparam int PTR_W        = 2;

    localparam logic [7:0] CODE_CLEAR  = 8'hF4;
    localparam logic [7:0] CODE_CALC   = 8'hB4;
    localparam logic [7:0] CODE_RESULT = 8'hD4;
    localparam logic [7:0] CODE_DATA   = 8'h94;

    typedef enum logic [1:0] {
        ST_DATA  = 2'd0,
        ST_CLR   = 2'd1,
        ST_CALC  = 2'd2,
        ST_RES   = 2'd3
    } necc_state_e;
endpackage

// File: rtl/necc_mode_ctrl.sv
// Mode decoder: turns written mode codes into the block state and one-cycle
// clear / readout-start strobes. Assumes unknown codes must leave state alone.
module necc_mode_ctrl
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_we,
    input  logic [7:0]  mode_code,
    output necc_state_e state,
    output logic        clr,
    output logic        rd_start
);
    // Strobes that act in the same edge as the mode write.
    always_comb begin
        clr      = mode_we && (mode_code == CODE_CLEAR);
        rd_start = mode_we && (mode_code == CODE_RESULT);
    end

    // State register updated only by recognised codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DATA;
        end else if (mode_we) begin
            case (mode_code)
                CODE_CLEAR:  state <= ST_CLR;
                CODE_CALC:   state <= ST_CALC;
                CODE_RESULT: state <= ST_RES;
                CODE_DATA:   state <= ST_DATA;
                default:     state <= state;
            endcase
        end
    end
endmodule

// File: rtl/necc_half_acc.sv
// One Hamming accumulator for a half-sector. Takes a 16-bit word as two bytes
// at an even byte address and its odd neighbour. Assumes base_idx is even.
module necc_half_acc #(
    parameter int ADDR_W = 8,
    localparam int LP_W  = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [ADDR_W-1:0] base_idx,
    input  logic [15:0]       word,
    output logic [LP_W-1:0]   lp,
    output logic [7:0]        col
);
    logic [5:0]        cp;
    logic [ADDR_W-1:0] idx_hi;
    logic [LP_W-1:0]   lp_delta;
    logic [5:0]        cp_delta;

    // Line-parity contribution of one byte at one address.
    function automatic logic [LP_W-1:0] lp_term(input logic [7:0] b,
                                                 input logic [ADDR_W-1:0] a);
        logic [LP_W-1:0] t;
        logic            p;
        p = ^b;
        for (int k = 0; k < ADDR_W; k++) begin
            t[2*k+1] = p & a[k];
            t[2*k]   = p & ~a[k];
        end
        return t;
    endfunction

    // Column-parity contribution of one byte.
    function automatic logic [5:0] cp_term(input logic [7:0] b);
        return {^(b & 8'hF0), ^(b & 8'h0F), ^(b & 8'hCC),
                ^(b & 8'h33), ^(b & 8'hAA), ^(b & 8'h55)};
    endfunction

    // Combined change from both bytes of the word.
    always_comb begin
        idx_hi   = base_idx | ADDR_W'(1);
        lp_delta = lp_term(word[7:0], base_idx) ^ lp_term(word[15:8], idx_hi);
        cp_delta = cp_term(word[7:0]) ^ cp_term(word[15:8]);
    end

    // Parity accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lp <= '0;
            cp <= '0;
        end else if (en) begin
            lp <= lp ^ lp_delta;
            cp <= cp ^ cp_delta;
        end
    end

    assign col = {cp, 2'b11};
endmodule

// File: rtl/necc_readout.sv
// Result sequencer: a pointer over three result words in the interleaved
// byte order. Assumes 16-bit line-parity fields.
module necc_readout
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             adv,
    input  logic [LP_W-1:0]  lp_a,
    input  logic [7:0]       col_a,
    input  logic [LP_W-1:0]  lp_b,
    input  logic [7:0]       col_b,
    output logic [PTR_W-1:0] ptr,
    output logic [WORD_W-1:0] res_word
);
    // Pointer: cleared by clear or start, wraps after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || start) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == PTR_W'(NUM_RES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // Word select in the fixed interleaved order.
    always_comb begin
        case (ptr)
            2'd0:    res_word = {lp_a[15:8], lp_a[7:0]};
            2'd1:    res_word = {lp_b[7:0], col_a};
            default: res_word = {col_b, lp_b[15:8]};
        endcase
    end
endmodule

// File: rtl/nand_ecc_dual.sv
// Top: dual-half Hamming ECC over a 512-byte sector streamed as 16-bit words.
// Assumes words arrive low byte first and that software issues mode codes.
module nand_ecc_dual
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_we,
    input  logic [7:0]  mode_code,
    input  logic        dat_valid,
    input  logic [15:0] dat_word,
    input  logic        res_rd,
    output logic [15:0] res_word
);
    necc_state_e       st;
    logic              clr;
    logic              rd_start;
    logic [CNT_W-1:0]  byte_cnt;
    logic              acc_go;
    logic [PTR_W-1:0]  rd_ptr;
    logic [LP_W-1:0]   lp_h  [2];
    logic [7:0]        col_h [2];

    necc_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_code (mode_code),
        .state     (st),
        .clr       (clr),
        .rd_start  (rd_start)
    );

    // Accept a word only while accumulating and inside the sector.
    assign acc_go = (st == ST_CALC) && dat_valid &&
                    (byte_cnt < CNT_W'(SECTOR_BYTES));

    // Byte index: two bytes per accepted word, saturating at the sector end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            byte_cnt <= '0;
        end else if (acc_go) begin
            byte_cnt <= byte_cnt + CNT_W'(2);
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        necc_half_acc #(.ADDR_W(ADDR_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .en       (acc_go && (byte_cnt[ADDR_W] == 1'(h))),
            .base_idx (byte_cnt[ADDR_W-1:0]),
            .word     (dat_word),
            .lp       (lp_h[h]),
            .col      (col_h[h])
        );
    end

    necc_readout u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .start    (rd_start),
        .adv      ((st == ST_RES) && res_rd),
        .lp_a     (lp_h[0]),
        .col_a    (col_h[0]),
        .lp_b     (lp_h[1]),
        .col_b    (col_h[1]),
        .ptr      (rd_ptr),
        .res_word (res_word)
    );
endmodule

// File: rtl/nand_ecc_dual_chk.sv
// Checker for nand_ecc_dual: cycle properties on index, pointer and output.
module nand_ecc_dual_chk
    import nand_ecc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_we,
    input logic [7:0]       mode_code,
    input logic             dat_valid,
    input logic             res_rd,
    input logic [15:0]      res_word,
    input necc_state_e      state,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [PTR_W-1:0] ptr
);
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(SECTOR_BYTES));

    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC && dat_valid && !mode_we &&
         byte_cnt < CNT_W'(SECTOR_BYTES))
        |=> byte_cnt == $past(byte_cnt) + CNT_W'(2));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_code == CODE_CLEAR) |=> (byte_cnt == '0 && ptr == '0));

    assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < PTR_W'(NUM_RES));

    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RES && res_rd && !mode_we && ptr == PTR_W'(2)) |=> ptr == '0);

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !mode_we) |=> $stable(res_word));

    assert_col_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == PTR_W'(1)) |-> res_word[1:0] == 2'b11);

    assert_col_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == PTR_W'(2)) |-> res_word[9:8] == 2'b11);
endmodule

bind nand_ecc_dual nand_ecc_dual_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_code (mode_code),
    .dat_valid (dat_valid),
    .res_rd    (res_rd),
    .res_word  (res_word),
    .state     (st),
    .byte_cnt  (byte_cnt),
    .ptr       (rd_ptr)
);

// File: tb/nand_ecc_dual_test.sv
module nand_ecc_dual_test;
    localparam int CLK_NS  = 4;
    localparam int SEC_MAX = 520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_code = '0;
    logic        dat_valid = 1'b0;
    logic [15:0] dat_word = '0;
    logic        res_rd = 1'b0;
    logic [15:0] res_word;

    int checks = 0;
    int errors = 0;
    logic [7:0]  sec [SEC_MAX];
    logic [15:0] exp_q [$];

    always #(CLK_NS/2) clk = ~clk;

    nand_ecc_dual uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_code(mode_code),
        .dat_valid(dat_valid), .dat_word(dat_word), .res_rd(res_rd),
        .res_word(res_word)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [7:0] c);
        @(negedge clk);
        mode_we = 1'b1; mode_code = c;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w);
        @(negedge clk);
        dat_valid = 1'b1; dat_word = w;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic stream(input int nbytes);
        for (int i = 0; i < nbytes; i += 2) put_word({sec[i+1], sec[i]});
    endtask

    // Reference code of one half, from the parity definitions.
    task automatic half_code(input int h, output logic [15:0] lp,
                             output logic [7:0] col);
        logic [5:0] cp;
        lp = '0; cp = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = sec[h*256 + i];
            for (int k = 0; k < 8; k++) begin
                if (i[k]) lp[2*k+1] ^= ^b; else lp[2*k] ^= ^b;
            end
            cp[0] ^= b[0]^b[2]^b[4]^b[6];
            cp[1] ^= b[1]^b[3]^b[5]^b[7];
            cp[2] ^= b[0]^b[1]^b[4]^b[5];
            cp[3] ^= b[2]^b[3]^b[6]^b[7];
            cp[4] ^= b[0]^b[1]^b[2]^b[3];
            cp[5] ^= b[4]^b[5]^b[6]^b[7];
        end
        col = {cp, 2'b11};
    endtask

    // Driver side of the scoreboard: push the three expected words.
    task automatic push_expected();
        logic [15:0] la, lb;
        logic [7:0]  ca, cb;
        half_code(0, la, ca);
        half_code(1, lb, cb);
        exp_q.push_back(la);
        exp_q.push_back({lb[7:0], ca});
        exp_q.push_back({cb, lb[15:8]});
    endtask

    // Monitor side: compare current word with the queue head, then read.
    task automatic read_check(input string tag);
        logic [15:0] e;
        @(negedge clk);
        e = exp_q.pop_front();
        chk(res_word === e, tag, res_word, e);
        res_rd = 1'b1;
        @(negedge clk);
        res_rd = 1'b0;
    endtask

    task automatic fill(input int seed);
        int s = seed;
        for (int i = 0; i < SEC_MAX; i++) begin
            s = s * 1103515245 + 12345;
            sec[i] = s[23:16];
        end
    endtask

    task automatic clear_sec();
        for (int i = 0; i < SEC_MAX; i++) sec[i] = 8'h00;
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_word === 16'h0000, "R1", res_word, 16'h0000);

        // All-zero sector: clear, dummy read, accumulate, read out, wrap.
        clear_sec();
        set_mode(8'hF4); put_word(16'hBEEF);
        set_mode(8'hB4); stream(512);
        set_mode(8'hD4);
        push_expected();
        exp_q.push_back(exp_q[0]);
        read_check("R2"); read_check("R5"); read_check("R5");
        read_check("R9");

        // Pseudo-random sector with a nonzero dummy read.
        fill(7);
        set_mode(8'hF4); put_word(16'hA5A5);
        set_mode(8'hB4); stream(512);
        set_mode(8'hD4);
        push_expected();
        read_check("R4"); read_check("R3"); read_check("R8");

        // Single set bit at byte 300 lands only in the second code.
        clear_sec(); sec[300] = 8'h01;
        set_mode(8'hF4); set_mode(8'hB4); stream(512);
        set_mode(8'hD4);
        push_expected();
        read_check("R6"); read_check("R6"); read_check("R6");

        // Extra words past the sector end must be ignored.
        fill(99);
        set_mode(8'hF4); set_mode(8'hB4); stream(512);
        put_word(16'h1234); put_word(16'hFFFF); put_word(16'h8001);
        set_mode(8'hD4);
        push_expected();
        read_check("R7"); read_check("R7"); read_check("R7");

        // Unknown code mid-stream, then data-mode inertness.
        fill(31);
        set_mode(8'hF4); set_mode(8'hB4); stream(200);
        set_mode(8'h55);
        for (int i = 200; i < 512; i += 2) put_word({sec[i+1], sec[i]});
        set_mode(8'hD4);
        push_expected();
        w1 = exp_q[1];
        read_check("R11");
        set_mode(8'h94);
        @(negedge clk); res_rd = 1'b1;
        @(negedge clk); res_rd = 1'b0;
        put_word(16'h7777);
        @(negedge clk);
        chk(res_word === w1, "R10", res_word, w1);
        exp_q.delete();
        set_mode(8'hD4);
        push_expected();
        read_check("R10"); read_check("R10"); read_check("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule